// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of peripheral interrupt request lines and a processor core. It decides when the core has to be interrupted, and it tells the core which interrupt number to run and at which vector table byte address to fetch the handler. Each line has four pieces of state:

- a device arm bit;
- a controller enable bit;
- a priority field;
- a pending flag that records a trigger until the line is serviced.

A global enable gates every ordinary line. A separate non-maskable input bypasses all of the masking.

The core takes an interrupt by pulsing `ack` while `irq_req` is high. At that point the controller clears the winner's pending flag and pushes the winner's level onto an internal nesting stack. The top of the stack is the current execution level, and only a strictly more urgent request can preempt it. The handler finishes with an `eoi` pulse, which pops the stack and restores the level that was interrupted. Software updates the arm and enable bits through separate set and clear strobe vectors, with one bit per line. Priorities are written through a per-line strobe that shares one data bus.

Top module: `irq_prio_ctrl`

## Requirements
- R1: An ordinary line raises `irq_req` only if all of the following hold: it is pending, it is armed, it is enabled, the global enable is set, and its level is strictly below `exec_level`. If any one of these is false, no request is made for that line.
- R2: A trigger that arrives while any other condition is false sets the pending flag. The flag is kept, and the request appears as soon as the last missing condition becomes true, whatever order the conditions arrive in.
- R3: A lower priority value wins over a higher one, and 0 is the most urgent value. Among eligible lines with equal priority, the line with the lower index wins.
- R4: An active interrupt is preempted only by a strictly more urgent request. A request with a level equal to `exec_level` is not signalled.
- R5: Line i carries interrupt number 16+i, and the NMI carries number 2. `irq_vec_addr` is always four times `irq_num`, so line 4 (number 20) gives 0x50 and the NMI gives 0x08.
- R6: A pending NMI is signalled with `irq_is_nmi`=1 whatever the global enable and per-line bits are, and it wins over every line. It is not signalled again while an NMI is already active (`exec_level`=0).
- R7: A one-bit in `en_set` sets that line's enable, and a one-bit in `en_clr` clears it. If both are set for the same line in the same cycle, the clear wins. The arm strobes `arm_set` and `arm_clr` work the same way, and so do `gie_set` and `gie_clr`.
- R8: `ack` while `irq_req` is high clears the winner's pending flag, or the NMI's pending flag. On the next cycle `exec_level` equals the winner's level: priority p gives level p+1, and the NMI gives level 0.
- R9: `eoi` pops the nesting stack, and `exec_level` returns to the level that was in force before the last acknowledge.
- R10: With nothing active, `exec_level` is 2^PRIO_W+1 (9 by default). This value is less urgent than every level that can be configured.
- R11: While `irq_req` stays high and no input changes the state, `irq_num` and `irq_vec_addr` hold their values.
- R12: After reset nothing is pending, armed or enabled. All priorities are 0, the global enable is clear, `irq_req` is low and `exec_level` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | N_LINES | Per-line trigger event pulse |
| arm_set | input | N_LINES | Set device arm bits |
| arm_clr | input | N_LINES | Clear device arm bits |
| en_set | input | N_LINES | Set controller enable bits |
| en_clr | input | N_LINES | Clear controller enable bits |
| prio_we | input | N_LINES | Per-line priority write strobe |
| prio_wdata | input | PRIO_W | Priority value to write |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| nmi_trig | input | 1 | Non-maskable trigger pulse |
| ack | input | 1 | Core accepts the signalled interrupt |
| eoi | input | 1 | End of interrupt, pops the nesting stack |
| irq_req | output | 1 | Interrupt request to the core |
| irq_is_nmi | output | 1 | Signalled interrupt is the NMI |
| irq_num | output | NUM_W | Interrupt number of the winner |
| irq_vec_addr | output | NUM_W+2 | Vector table byte address |
| exec_level | output | PRIO_W+1 | Current execution level |

## Verification
The assertions assume that the core pulses `ack` only while `irq_req` is high, that `ack` and `eoi` never fall in the same cycle, and that `eoi` is sent only for an interrupt that was actually taken. The stimulus keeps to these rules: every acknowledge waits until a check has seen the request raised, and every `eoi` follows its own `ack` in a later cycle. Configuration writes and triggers are one-cycle pulses that never overlap an acknowledge, so the hold check for number stability gets stretches with no state changes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Vector byte address: one 32-bit word per interrupt number.
  function automatic logic [17:0] vec_byte_addr(input logic [15:0] num);
    return {num, 2'b00};
  endfunction

  // Execution level of an ordinary line: priority shifted past the NMI level.
  function automatic logic [15:0] line_level(input logic [15:0] prio);
    return prio + 16'd1;
  endfunction
endpackage

// File: rtl/irqc_lines.sv
module irqc_lines #(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_LINES-1:0]              trig,
  input  logic [N_LINES-1:0]              arm_set,
  input  logic [N_LINES-1:0]              arm_clr,
  input  logic [N_LINES-1:0]              en_set,
  input  logic [N_LINES-1:0]              en_clr,
  input  logic [N_LINES-1:0]              prio_we,
  input  logic [PRIO_W-1:0]               prio_wdata,
  input  logic [N_LINES-1:0]              pend_clr,
  output logic [N_LINES-1:0]              pend,
  output logic [N_LINES-1:0]              armed,
  output logic [N_LINES-1:0]              enab,
  output logic [N_LINES-1:0][PRIO_W-1:0]  prio
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i]  <= 1'b0;
        armed[i] <= 1'b0;
        enab[i]  <= 1'b0;
        prio[i]  <= '0;
      end else begin
        // A new trigger wins over a clear in the same cycle.
        pend[i]  <= (pend[i] & ~pend_clr[i]) | trig[i];
        armed[i] <= (armed[i] | arm_set[i]) & ~arm_clr[i];
        enab[i]  <= (enab[i] | en_set[i]) & ~en_clr[i];
        if (prio_we[i]) prio[i] <= prio_wdata;
      end
    end

    assert_en_clr_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_set[i] && en_clr[i]) |=> !enab[i]);
    assert_pend_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !pend_clr[i]) |=> pend[i]);
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int N_LINES = 8,
  parameter int PRIO_W  = 3,
  localparam int LVL_W  = PRIO_W + 1,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]              pend,
  input  logic [N_LINES-1:0]              armed,
  input  logic [N_LINES-1:0]              enab,
  input  logic [N_LINES-1:0][PRIO_W-1:0]  prio,
  input  logic                            gie,
  input  logic                            nmi_pend,
  input  logic [LVL_W-1:0]                cur_lvl,
  output logic                            req,
  output logic                            is_nmi,
  output logic [IDX_W-1:0]                win_idx,
  output logic [LVL_W-1:0]                win_lvl
);
  import irqc_pkg::*;
  localparam logic [LVL_W-1:0] NMI_LVL = '0;

  logic [N_LINES-1:0] elig;
  logic               line_hit;
  logic [LVL_W-1:0]   best_lvl;
  logic [IDX_W-1:0]   best_idx;

  always_comb begin
    line_hit = 1'b0;
    best_lvl = '1;
    best_idx = '0;
    for (int i = 0; i < N_LINES; i++) begin
      logic [LVL_W-1:0] lv;
      lv = LVL_W'(line_level(16'(prio[i])));
      elig[i] = pend[i] & armed[i] & enab[i] & gie & (lv < cur_lvl);
      // Strict compare keeps the lowest index on a tie.
      if (elig[i] && (!line_hit || lv < best_lvl)) begin
        line_hit = 1'b1;
        best_lvl = lv;
        best_idx = IDX_W'(i);
      end
    end
  end

  logic nmi_ok;
  assign nmi_ok  = nmi_pend && (cur_lvl != NMI_LVL);
  assign req     = nmi_ok | line_hit;
  assign is_nmi  = nmi_ok;
  assign win_idx = best_idx;
  assign win_lvl = nmi_ok ? NMI_LVL : best_lvl;
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest #(
  parameter int PRIO_W = 3,
  localparam int LVL_W = PRIO_W + 1,
  localparam int DEPTH = (1 << PRIO_W) + 1,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'((1 << PRIO_W) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] cur_lvl,
  output logic [PTR_W-1:0] depth
);
  logic [LVL_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (push) begin
      ptr <= ptr + PTR_W'(1);
    end else if (pop && ptr != '0) begin
      ptr <= ptr - PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[ptr] <= push_lvl;
  end

  assign cur_lvl = (ptr == '0) ? IDLE_LVL : slot[ptr - PTR_W'(1)];
  assign depth   = ptr;

  assert_nest_strict_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_lvl < cur_lvl));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(DEPTH));
  assert_pop_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && ptr != '0) |=> (ptr == $past(ptr) - PTR_W'(1)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_LINES   = 8,
  parameter int PRIO_W    = 3,
  parameter int NUM_W     = 8,
  parameter int LINE_BASE = 16,
  parameter int NMI_NUM   = 2,
  localparam int LVL_W    = PRIO_W + 1,
  localparam int IDX_W    = $clog2(N_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_LINES-1:0]   trig,
  input  logic [N_LINES-1:0]   arm_set,
  input  logic [N_LINES-1:0]   arm_clr,
  input  logic [N_LINES-1:0]   en_set,
  input  logic [N_LINES-1:0]   en_clr,
  input  logic [N_LINES-1:0]   prio_we,
  input  logic [PRIO_W-1:0]    prio_wdata,
  input  logic                 gie_set,
  input  logic                 gie_clr,
  input  logic                 nmi_trig,
  input  logic                 ack,
  input  logic                 eoi,
  output logic                 irq_req,
  output logic                 irq_is_nmi,
  output logic [NUM_W-1:0]     irq_num,
  output logic [NUM_W+1:0]     irq_vec_addr,
  output logic [LVL_W-1:0]     exec_level
);
  import irqc_pkg::*;
  localparam int PTR_W = $clog2((1 << PRIO_W) + 2);

  logic [N_LINES-1:0]             pend, armed, enab, pend_clr;
  logic [N_LINES-1:0][PRIO_W-1:0] prio;
  logic                           gie_q, nmi_pend;
  logic [IDX_W-1:0]               win_idx;
  logic [LVL_W-1:0]               win_lvl;
  logic [PTR_W-1:0]               depth;

  // Named internal events.
  logic take, take_line, take_nmi, quiet;
  assign take      = ack & irq_req;
  assign take_nmi  = take & irq_is_nmi;
  assign take_line = take & ~irq_is_nmi;
  assign pend_clr  = take_line ? (N_LINES'(1) << win_idx) : '0;
  assign quiet     = ~|{trig, arm_set, arm_clr, en_set, en_clr, prio_we,
                        gie_set, gie_clr, nmi_trig, ack, eoi};

  irqc_lines #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_lines (
    .clk, .rst_n, .trig, .arm_set, .arm_clr, .en_set, .en_clr,
    .prio_we, .prio_wdata, .pend_clr, .pend, .armed, .enab, .prio
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      gie_q    <= (gie_q | gie_set) & ~gie_clr;
      nmi_pend <= (nmi_pend & ~take_nmi) | nmi_trig;
    end
  end

  irqc_arb #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_arb (
    .pend, .armed, .enab, .prio, .gie(gie_q), .nmi_pend,
    .cur_lvl(exec_level), .req(irq_req), .is_nmi(irq_is_nmi),
    .win_idx, .win_lvl
  );

  irqc_nest #(.PRIO_W(PRIO_W)) u_nest (
    .clk, .rst_n, .push(take), .push_lvl(win_lvl), .pop(eoi),
    .cur_lvl(exec_level), .depth
  );

  assign irq_num      = irq_is_nmi ? NUM_W'(NMI_NUM)
                                   : NUM_W'(LINE_BASE) + NUM_W'(win_idx);
  assign irq_vec_addr = (NUM_W+2)'(vec_byte_addr(16'(irq_num)));

  assert_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_is_nmi) |-> (gie_q && pend[win_idx] && armed[win_idx] && enab[win_idx]));
  assert_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (win_lvl < exec_level));
  assert_nmi_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && exec_level != '0) |-> (irq_req && irq_is_nmi));
  assert_ack_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (exec_level == $past(win_lvl)));
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_line && !trig[win_idx]) |=> !pend[$past(win_idx)]);
  assert_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && quiet) |=> (irq_req && $stable(irq_num)));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int N = 8, PW = 3, NW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] trig, arm_set, arm_clr, en_set, en_clr, prio_we;
  logic [PW-1:0] prio_wdata;
  logic gie_set, gie_clr, nmi_trig, ack, eoi;
  logic irq_req, irq_is_nmi;
  logic [NW-1:0] irq_num;
  logic [NW+1:0] irq_vec_addr;
  logic [PW:0] exec_level;

  int n_chk = 0, n_bad = 0;
  logic [NW:0] sb[$];   // {expected is_nmi, expected number}

  always #2 clk = ~clk;

  irq_prio_ctrl uut (.*);

  task automatic clear_in();
    trig = '0; arm_set = '0; arm_clr = '0; en_set = '0; en_clr = '0;
    prio_we = '0; prio_wdata = '0; gie_set = 0; gie_clr = 0;
    nmi_trig = 0; ack = 0; eoi = 0;
  endtask
  task automatic step(); @(posedge clk); #1; clear_in(); endtask
  task automatic go(); @(posedge clk); #1; endtask

  task automatic t_trig(input logic [N-1:0] m); go(); trig = m; step(); endtask
  task automatic t_arm(input logic [N-1:0] m); go(); arm_set = m; step(); endtask
  task automatic t_en(input logic [N-1:0] s, input logic [N-1:0] c);
    go(); en_set = s; en_clr = c; step();
  endtask
  task automatic t_prio(input logic [N-1:0] m, input int p);
    go(); prio_we = m; prio_wdata = PW'(p); step();
  endtask
  task automatic t_gie(input bit on);
    go(); gie_set = on; gie_clr = !on; step();
  endtask
  task automatic t_nmi(); go(); nmi_trig = 1; step(); endtask
  task automatic t_eoi(); go(); eoi = 1; step(); endtask
  task automatic setup_line(input int i, input int p);
    t_prio(N'(1) << i, p); t_arm(N'(1) << i); t_en(N'(1) << i, '0);
  endtask
  // Driver: queue the expected winner, then accept it.
  task automatic t_take(input bit nmi, input int num);
    sb.push_back({nmi, NW'(num)});
    go(); ack = 1; step();
  endtask

  task automatic chk_req(input bit er, input int en, input string tag);
    @(negedge clk);
    n_chk++;
    if (irq_req !== er || (er && irq_num !== NW'(en))) begin
      n_bad++;
      $display("FAIL %s: req=%0b num=%0d expected req=%0b num=%0d",
               tag, irq_req, irq_num, er, en);
    end
  endtask
  task automatic chk_lvl(input int el, input string tag);
    @(negedge clk);
    n_chk++;
    if (exec_level !== (PW+1)'(el)) begin
      n_bad++;
      $display("FAIL %s: exec_level=%0d expected %0d", tag, exec_level, el);
    end
  endtask

  // Monitor: compare each accepted interrupt against the scoreboard (R5).
  always @(negedge clk) begin
    if (rst_n && ack) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R5: unexpected ack, num=%0d expected none", irq_num);
      end else begin
        logic [NW:0] e;
        e = sb.pop_front();
        if (!irq_req || irq_is_nmi !== e[NW] || irq_num !== e[NW-1:0] ||
            irq_vec_addr !== {2'b00, e[NW-1:0]} * 4) begin
          n_bad++;
          $display("FAIL R5: req=%0b nmi=%0b num=%0d addr=%0h expected nmi=%0b num=%0d addr=%0h",
                   irq_req, irq_is_nmi, irq_num, irq_vec_addr, e[NW], e[NW-1:0],
                   {2'b00, e[NW-1:0]} * 4);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_req(0, 0, "R12 reset");
    chk_lvl(9, "R10 idle level");

    // R1/R2: conditions arrive one by one after the trigger.
    t_prio(8'h10, 2);
    t_trig(8'h10);      chk_req(0, 0, "R2 pending only");
    t_arm(8'h10);       chk_req(0, 0, "R1 not enabled");
    t_en(8'h10, '0);    chk_req(0, 0, "R1 no global enable");
    t_gie(1);           chk_req(1, 20, "R2 request after last gate");
    t_take(0, 20);      chk_lvl(3, "R8 level after ack");
    chk_req(0, 0, "R8 pending cleared");

    // R4: equal level does not preempt; higher does.
    setup_line(1, 2); t_trig(8'h02); chk_req(0, 0, "R4 equal no preempt");
    setup_line(6, 1); t_trig(8'h40); chk_req(1, 22, "R4 preempt");
    t_take(0, 22);    chk_lvl(2, "R8 nested level");
    t_eoi();          chk_lvl(3, "R9 restore");
    chk_req(0, 0, "R9 still equal");
    t_eoi();          chk_lvl(9, "R9 idle restore");
    chk_req(1, 17, "R9 held line taken");

    // R3: tie breaks by lower number; lower priority value wins.
    setup_line(3, 1); setup_line(5, 1); t_trig(8'h28);
    chk_req(1, 19, "R3 tie lower number");
    t_take(0, 19); t_eoi(); chk_req(1, 21, "R3 second of tie");
    t_take(0, 21); t_eoi(); chk_req(1, 17, "R3 lower urgency last");
    t_take(0, 17); t_eoi(); chk_req(0, 0, "R3 all served");
    setup_line(0, 3); setup_line(7, 0); t_trig(8'h81);
    chk_req(1, 23, "R3 priority beats index");
    t_take(0, 23); t_eoi(); chk_req(1, 16, "R3 remaining");
    t_take(0, 16); t_eoi();

    // R7: enable strobes, clear wins.
    t_prio(8'h04, 0); t_arm(8'h04); t_trig(8'h04);
    chk_req(0, 0, "R7 disabled line");
    t_en(8'h04, 8'h04); chk_req(0, 0, "R7 clear wins");
    t_en(8'h04, '0);    chk_req(1, 18, "R7 set");
    t_en('0, 8'h04);    chk_req(0, 0, "R7 clear");
    t_en(8'h04, '0);    t_take(0, 18); t_eoi();

    // R6: NMI bypasses global enable, does not nest itself.
    t_gie(0); t_trig(8'h20); chk_req(0, 0, "R1 global enable off");
    t_nmi();  chk_req(1, 2, "R6 nmi signalled");
    t_take(1, 2);  chk_lvl(0, "R6 nmi level");
    t_nmi();  chk_req(0, 0, "R6 nmi no self nest");
    t_eoi();  chk_lvl(9, "R9 after nmi");
    chk_req(1, 2, "R6 second nmi");
    t_take(1, 2); t_eoi();
    chk_req(0, 0, "R1 line held by gie");
    t_gie(1); chk_req(1, 21, "R2 gie last gate");

    // R11: hold with no input activity.
    chk_req(1, 21, "R11 hold 1");
    chk_req(1, 21, "R11 hold 2");
    t_take(0, 21); t_eoi();
    chk_lvl(9, "R10 final idle");
    chk_req(0, 0, "R8 final quiet");

    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R5: %0d takes unmatched, expected 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule